// File: doc/BRIEF.md
# Intrusion Alarm Mode Controller

This block is the top-level sequencer of an intrusion alarm. It keeps the alarm in one of six modes: idle, exit countdown, guarding, sounding, post-alarm report and entry countdown. A one-cycle code-accepted pulse from a keypad decoder moves it between them. A 2-bit zone input names the sensor zone that tripped, where 0 means no trip. A coarse time-base tick feeds a delay counter that times the exit and entry windows.

The block drives the siren enable and a 2-bit zone indicator. The indicator keeps showing the zone that tripped until the alarm has been acknowledged twice. The first accepted code after a trip silences the siren and keeps the indicator. The second accepted code clears the indicator and returns the alarm to idle. A trip in zone 1, where the control box sits, does not sound at once. It opens an entry window so the owner can key the code first. The mode is also given on an output, so that other logic can act on it.

Top module: `alarm_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (idle), siren_o is 0 and light_o is 0. Mode codes are: 0 idle, 1 exit countdown, 2 guarding, 3 sounding, 4 report, 5 entry countdown.
- R2: In idle, go_i moves the mode to 1 on the next edge. Without go_i the mode stays 0, whatever zone_i and tick_i are.
- R3: In exit countdown, go_i returns the mode to 0. Once LEAVE_TICKS ticks have been counted with no go_i, the next edge moves the mode to 2. zone_i has no effect in this mode.
- R4: In guarding, go_i returns the mode to 0. Without go_i, zone_i = 1 moves the mode to 5 and sets light_o to 1. zone_i = 2 or 3 moves the mode to 3, sets siren_o and sets light_o to the zone. zone_i = 0 keeps the mode at 2.
- R5: In entry countdown, go_i returns the mode to 0 and leaves light_o unchanged. Once RETURN_TICKS ticks have been counted with no go_i, the next edge moves the mode to 3 and sets siren_o. RETURN_TICKS defaults to CODE_DIGITS + 1, which is 5.
- R6: In sounding, go_i moves the mode to 4, clears siren_o and keeps light_o. In report, go_i moves the mode to 0 and clears light_o.
- R7: The delay count starts from zero on each entry to a timed mode. Ticks received in any other mode are not counted.
- R8: When go_i arrives in the same cycle as an expired delay or a zone trip, go_i decides the transition.
- R9: siren_o is 1 exactly while the mode is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | 1 | One-cycle code-accepted pulse |
| zone_i | input | 2 | Tripped zone, 0 = none |
| tick_i | input | 1 | Time-base tick for the delays |
| siren_o | output | 1 | Siren enable |
| light_o | output | 2 | Latched tripped-zone indicator |
| mode_o | output | 3 | Current mode code |

## Verification
From the guarding mode, all four zone values are applied in turn. This separates the silent path, the grace path and the immediate-sound path, and shows which zone number the indicator latches. The exit and entry windows are driven with one tick fewer than the limit and then with exactly the limit. This places each timeout on its exact edge. It also shows that ticks received while guarding do not shorten the entry window. Pulses of go_i arrive together with an expired delay and with a trip, which shows that the code pulse wins. Zone and tick activity in idle and in exit countdown shows that those inputs have no effect there.

// File: rtl/alarm_ctrl.sv
module alarm_ctrl #(
  parameter int CODE_DIGITS  = 4,
  parameter int LEAVE_TICKS  = 1,
  parameter int RETURN_TICKS = CODE_DIGITS + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [1:0] zone_i,
  input  logic       tick_i,
  output logic       siren_o,
  output logic [1:0] light_o,
  output logic [2:0] mode_o
);
  localparam int MAXT = (LEAVE_TICKS > RETURN_TICKS) ? LEAVE_TICKS : RETURN_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  typedef enum logic [2:0] {
    M_IDLE = 3'd0, M_EXIT = 3'd1, M_GUARD = 3'd2,
    M_SOUND = 3'd3, M_REPORT = 3'd4, M_ENTRY = 3'd5
  } mode_t;

  mode_t          st, nx;
  logic [CW-1:0]  cnt, lim;
  logic           timed, expired, siren_d;
  logic [1:0]     light_d;

  assign timed   = (st == M_EXIT) || (st == M_ENTRY);
  assign lim     = (st == M_EXIT) ? CW'(LEAVE_TICKS) : CW'(RETURN_TICKS);
  assign expired = timed && (cnt >= lim);
  assign mode_o  = st;

  always_comb begin
    nx      = st;
    siren_d = siren_o;
    light_d = light_o;
    case (st)
      M_IDLE:   if (go_i) nx = M_EXIT;
      M_EXIT:   if (go_i) nx = M_IDLE;
                else if (expired) nx = M_GUARD;
      M_GUARD:  if (go_i) nx = M_IDLE;
                else if (zone_i == 2'd1) begin
                  nx = M_ENTRY; light_d = zone_i;
                end else if (zone_i != 2'd0) begin
                  nx = M_SOUND; siren_d = 1'b1; light_d = zone_i;
                end
      M_ENTRY:  if (go_i) nx = M_IDLE;
                else if (expired) begin
                  nx = M_SOUND; siren_d = 1'b1;
                end
      M_SOUND:  if (go_i) begin
                  nx = M_REPORT; siren_d = 1'b0;
                end
      M_REPORT: if (go_i) begin
                  nx = M_IDLE; light_d = 2'd0;
                end
      default:  nx = M_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= M_IDLE;
      siren_o <= 1'b0;
      light_o <= 2'd0;
      cnt     <= '0;
    end else begin
      st      <= nx;
      siren_o <= siren_d;
      light_o <= light_d;
      if (nx != st || !timed) cnt <= '0;
      else if (tick_i && cnt < lim) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/alarm_ctrl_chk.sv
module alarm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go_i,
  input logic [1:0] zone_i,
  input logic       tick_i,
  input logic       siren_o,
  input logic [1:0] light_o,
  input logic [2:0] mode_o
);
  p_idle_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd0 && go_i) |=> mode_o == 3'd1);

  p_guard_go_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 && go_i) |=> mode_o == 3'd0);

  p_zone1_grace_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 && !go_i && zone_i == 2'd1) |=> (mode_o == 3'd5 && light_o == 2'd1));

  p_report_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && go_i) |=> (mode_o == 3'd0 && light_o == 2'd0));

  p_silence_keeps_light_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && go_i) |=> (mode_o == 3'd4 && !siren_o && $stable(light_o)));

  p_siren_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    siren_o == (mode_o == 3'd3));

  p_entry_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5 && go_i) |=> (mode_o == 3'd0 && $stable(light_o)));
endmodule

bind alarm_ctrl alarm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go_i(go_i), .zone_i(zone_i), .tick_i(tick_i),
  .siren_o(siren_o), .light_o(light_o), .mode_o(mode_o)
);

// File: tb/sim_alarm_ctrl.sv
module sim_alarm_ctrl;
  localparam int LT = 1;
  localparam int RT = 5;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, tick = 1'b0;
  logic [1:0] zone = 2'd0;
  logic siren;
  logic [1:0] light;
  logic [2:0] mode;

  int checks = 0, fails = 0;
  int em = 0, el = 0, ec = 0;
  bit es = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alarm_ctrl u0 (.clk(clk), .rst_n(rst_n), .go_i(go), .zone_i(zone), .tick_i(tick),
                 .siren_o(siren), .light_o(light), .mode_o(mode));

  task automatic check(input string tag);
    checks++;
    if (mode !== 3'(em) || siren !== es || light !== 2'(el)) begin
      fails++;
      $display("FAIL %s: mode/siren/light = %0d/%0d/%0d, expected %0d/%0d/%0d",
               tag, mode, siren, light, em, es, el);
    end
  endtask

  task automatic step(input bit g, input int z, input bit t, input string tag);
    int nm;
    bit timed;
    int lim;
    go = g; zone = 2'(z); tick = t;
    timed = (em == 1 || em == 5);
    lim = (em == 1) ? LT : RT;
    nm = em;
    case (em)
      0: if (g) nm = 1;
      1: if (g) nm = 0; else if (ec >= lim) nm = 2;
      2: if (g) nm = 0; else if (z == 1) begin nm = 5; el = 1; end
         else if (z != 0) begin nm = 3; es = 1'b1; el = z; end
      5: if (g) nm = 0; else if (ec >= lim) begin nm = 3; es = 1'b1; end
      3: if (g) begin nm = 4; es = 1'b0; end
      4: if (g) begin nm = 0; el = 0; end
      default: nm = 0;
    endcase
    if (nm != em || !timed) ec = 0;
    else if (t && ec < lim) ec++;
    em = nm;
    @(posedge clk); #1;
    go = 1'b0; zone = 2'd0; tick = 1'b0;
    check(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;
    em = 0; es = 1'b0; el = 0; ec = 0;
  endtask

  task automatic to_guard();
    step(1, 0, 0, "R2 arm");
    for (int i = 0; i < LT; i++) step(0, 0, 1, "R3 exit tick");
    step(0, 0, 0, "R3 exit expire");
  endtask

  initial begin
    do_reset();
    check("R1 reset");
    for (int z = 0; z < 4; z++) step(0, z, 1, "R2 idle ignores zone/tick");

    step(1, 0, 0, "R2 idle go");
    for (int z = 1; z < 4; z++) step(0, z, 0, "R3 exit ignores zone");
    step(1, 0, 1, "R3 exit go");
    to_guard();
    step(0, 0, 0, "R4 guard quiet");

    for (int z = 0; z < 4; z++) begin
      do_reset();
      to_guard();
      for (int i = 0; i < 7; i++) step(0, 0, 1, "R7 ticks while guarding");
      step(0, z, 0, "R4 zone sweep");
      if (z == 1) begin
        for (int i = 0; i < RT - 1; i++) step(0, 0, 1, "R7 entry tick");
        step(0, 0, 0, "R7 entry not yet expired");
        step(0, 0, 1, "R5 last tick");
        step(0, 0, 0, "R5 entry expire sounds");
      end
      if (mode == 3'd3) begin
        step(0, 0, 1, "R9 sounding holds");
        step(1, 0, 0, "R6 silence");
        step(0, 3, 1, "R6 report holds");
        step(1, 0, 0, "R6 clear");
      end
    end

    do_reset();
    to_guard();
    step(1, 3, 0, "R8 go beats trip");
    to_guard();
    step(0, 1, 0, "R4 zone1 grace");
    for (int i = 0; i < RT; i++) step(0, 0, 1, "R5 entry tick");
    step(1, 0, 0, "R8 go beats entry timeout");
    step(0, 0, 0, "R5 light kept after entry go");

    do_reset();
    step(1, 0, 0, "R2 arm");
    for (int i = 0; i < LT; i++) step(0, 0, 1, "R3 exit tick");
    step(1, 0, 0, "R8 go beats exit timeout");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule